// File: doc/BRIEF.md
# Per-core sticky security lock register

This block gives one processor core a small APB-mapped register file that holds its security lock bits. Software sets a lock by writing a one to its bit in the control word at offset 0x000. Each lock bit drives a registered output that goes to the core's lock pins. Once a bit is set, no bus write can clear it. Only a reset of the block clears it. The block sits in the core's own reset and power domain, so powering the core down and up again releases every lock.

The top of the 4 KB window holds twelve read-only identification bytes that software uses to discover the component. Every other offset is reserved. A reserved offset reads as zero and ignores writes. No transfer ever stalls or returns an error.

Top module: `seclock_regblock`

## Requirements
- R1: After reset both lock outputs are 0 and a read of offset 0x000 returns 0x00000000.
- R2: A completed APB write (psel, penable and pwrite high on a rising clock edge) to offset 0x000 with data bit 1 set drives lock_attr_o to 1 after that edge. Data bit 0 does the same for lock_vec_o. When both bits are set, both outputs go high on the same edge.
- R3: A lock bit that is 1 stays 1 whatever is written to offset 0x000, including all-zero data.
- R4: Writing 0 to a clear lock bit leaves it clear. A setup phase without penable changes no lock. A read of offset 0x000 changes no lock. A write to any other offset changes no lock.
- R5: A read of offset 0x000 returns lock_attr_o in bit 1 and lock_vec_o in bit 0, with bits [31:2] zero.
- R6: The identification offsets read as follows: 0xFD0=0x04, 0xFD4=0x00, 0xFD8=0x00, 0xFDC=0x00, 0xFE0=0x59, 0xFE4=0xB8, 0xFE8=0x0B, 0xFEC=0x00, 0xFF0=0x0D, 0xFF4=0xF0, 0xFF8=0x05, 0xFFC=0xB1.
- R7: Identification reads return zero in bits [31:8]. Reads of reserved offsets (0x004 to 0xFCC) return zero. An address with nonzero bits [1:0] counts as reserved.
- R8: pready is always 1 and pslverr is always 0, including for writes to reserved or read-only offsets.
- R9: Asserting rst_n low clears both lock outputs without waiting for a clock edge, even when they were set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the core |
| rst_n | input | 1 | Asynchronous active-low reset of the core domain |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write, 1 = write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, zero when not selected |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| lock_attr_o | output | 1 | Lock for the security attribution unit configuration (bit 1) |
| lock_vec_o | output | 1 | Lock for the secure vector table offset and the interrupt priority and routing fields (bit 0) |

## Verification
The embedded assertions watch several rules on every cycle. A set lock must stay set. A completed write of a one must set its lock on the next edge. A lock must never rise without such a write. The reserved upper bits of the control word and the identification words must read as zero.

Some behaviour can only be shown by the directed scenarios. These cover the exact identification byte at each offset, and the fact that writes to reserved or read-only offsets, setup-only phases and reads leave the locks untouched. They also cover the asynchronous clearing by reset and the timing of a set relative to the completing edge.

// File: rtl/seclock_pkg.sv
package seclock_pkg;

   typedef enum logic [1:0] {
      RGN_CTRL = 2'd0,
      RGN_IDENT = 2'd1,
      RGN_RSVD = 2'd2
   } region_e;

   localparam int unsigned IDENT_WORDS = 12;
   localparam int unsigned IDENT_IDX_W = 4;

   function automatic logic [7:0] ident_byte(input logic [IDENT_IDX_W-1:0] idx);
      logic [7:0] val;
      case (idx)
         4'd0:    val = 8'h04;
         4'd4:    val = 8'h59;
         4'd5:    val = 8'hB8;
         4'd6:    val = 8'h0B;
         4'd8:    val = 8'h0D;
         4'd9:    val = 8'hF0;
         4'd10:   val = 8'h05;
         4'd11:   val = 8'hB1;
         default: val = 8'h00;
      endcase
      return val;
   endfunction

endpackage

// File: rtl/seclock_apb_dec.sv
module seclock_apb_dec
   import seclock_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic                   psel,
   input  logic                   penable,
   input  logic                   pwrite,
   input  logic [ADDR_W-1:0]      paddr,
   output region_e                region,
   output logic [IDENT_IDX_W-1:0] ident_idx,
   output logic                   wr_ctrl
);
   localparam int unsigned WORD_W      = ADDR_W - 2;
   localparam int unsigned WORDS       = 2 ** WORD_W;
   localparam int unsigned IDENT_FIRST = WORDS - IDENT_WORDS;

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("seclock_apb_dec: ADDR_W must be at least 6");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              aligned;
   logic [WORD_W-1:0] ident_off;

   assign word      = paddr[ADDR_W-1:2];
   assign aligned   = (paddr[1:0] == 2'b00);
   assign ident_off = word - WORD_W'(IDENT_FIRST);
   assign ident_idx = ident_off[IDENT_IDX_W-1:0];

   always_comb begin
      if (!aligned)                             region = RGN_RSVD;
      else if (word == '0)                      region = RGN_CTRL;
      else if (word >= WORD_W'(IDENT_FIRST))    region = RGN_IDENT;
      else                                      region = RGN_RSVD;
   end

   assign wr_ctrl = psel && penable && pwrite && (region == RGN_CTRL);
endmodule

// File: rtl/seclock_lock_reg.sv
module seclock_lock_reg #(
   parameter int unsigned NUM_LOCKS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_ctrl,
   input  logic [NUM_LOCKS-1:0] set_bits,
   output logic [NUM_LOCKS-1:0] lock_q
);
   generate
      if (NUM_LOCKS < 1) begin : g_bad_locks
         $error("seclock_lock_reg: NUM_LOCKS must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      lock_q[i] <= 1'b0;
         else if (wr_ctrl && set_bits[i]) lock_q[i] <= 1'b1;
      end

      AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         lock_q[i] |=> lock_q[i]);                                   // R3
      AST_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_ctrl && set_bits[i]) |=> lock_q[i]);                    // R2
      AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (!lock_q[i] && !(wr_ctrl && set_bits[i])) |=> !lock_q[i]);  // R4
   end
endmodule

// File: rtl/seclock_rdmux.sv
module seclock_rdmux
   import seclock_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_LOCKS = 2
) (
   input  logic                   psel,
   input  region_e                region,
   input  logic [IDENT_IDX_W-1:0] ident_idx,
   input  logic [NUM_LOCKS-1:0]   lock_q,
   output logic [DATA_W-1:0]      rdata
);
   generate
      if (DATA_W < 8 || NUM_LOCKS > DATA_W) begin : g_bad_width
         $error("seclock_rdmux: DATA_W must hold a byte and all lock bits");
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (psel) begin
         case (region)
            RGN_CTRL:  rdata[NUM_LOCKS-1:0] = lock_q;
            RGN_IDENT: rdata[7:0] = ident_byte(ident_idx);
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/seclock_regblock.sv
module seclock_regblock
   import seclock_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_LOCKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic              lock_attr_o,
   output logic              lock_vec_o
);
   localparam int unsigned ATTR_BIT = 1;
   localparam int unsigned VEC_BIT  = 0;

   generate
      if (NUM_LOCKS != 2) begin : g_bad_count
         $error("seclock_regblock: exactly two lock outputs are wired");
      end
   endgenerate

   region_e                region;
   logic [IDENT_IDX_W-1:0] ident_idx;
   logic                   wr_ctrl;
   logic [NUM_LOCKS-1:0]   lock_q;
   logic                   unused_wdata;

   assign unused_wdata = ^pwdata[DATA_W-1:NUM_LOCKS];

   seclock_apb_dec #(.ADDR_W(ADDR_W)) u_dec (
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .region(region), .ident_idx(ident_idx), .wr_ctrl(wr_ctrl)
   );

   seclock_lock_reg #(.NUM_LOCKS(NUM_LOCKS)) u_locks (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
      .set_bits(pwdata[NUM_LOCKS-1:0]), .lock_q(lock_q)
   );

   seclock_rdmux #(.DATA_W(DATA_W), .NUM_LOCKS(NUM_LOCKS)) u_rd (
      .psel(psel), .region(region), .ident_idx(ident_idx),
      .lock_q(lock_q), .rdata(prdata)
   );

   assign pready      = 1'b1;
   assign pslverr     = 1'b0;
   assign lock_attr_o = lock_q[ATTR_BIT];
   assign lock_vec_o  = lock_q[VEC_BIT];

   AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && paddr == '0) |-> (prdata[DATA_W-1:NUM_LOCKS] == '0));  // R5
   AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && paddr == '0) |-> (prdata[1:0] == {lock_attr_o, lock_vec_o}));  // R5
   AST_IDENT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && region == RGN_IDENT) |-> (prdata[DATA_W-1:8] == '0));  // R7
   AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && region == RGN_RSVD) |-> (prdata == '0));  // R7
endmodule

// File: tb/sim_seclock_regblock.sv
module sim_seclock_regblock;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr, lock_attr_o, lock_vec_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seclock_regblock u0 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .pslverr(pslverr), .lock_attr_o(lock_attr_o), .lock_vec_o(lock_vec_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic chk_locks(input string req, input logic [1:0] exp);
      chk(req, {30'd0, lock_attr_o, lock_vec_o}, {30'd0, exp});
   endtask

   task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      chk("R8 write pready", {31'd0, pready}, 32'd1);
      chk("R8 write pslverr", {31'd0, pslverr}, 32'd0);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a; pwdata = 32'hFFFF_FFFF;
      @(negedge clk);
      penable = 1'b1;
      #1;
      d = prdata;
      chk("R8 read pslverr", {31'd0, pslverr}, 32'd0);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_locks("R9 async clear", 2'b00);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      logic [31:0] d;
      chk_locks("R1 reset outputs", 2'b00);
      apb_read(12'h000, d);
      chk("R1 reset ctrl read", d, 32'h0);
   endtask

   task automatic t_set_each();
      logic [31:0] d;
      apb_write(12'h000, 32'h0000_0000);
      chk_locks("R4 zero write keeps clear", 2'b00);
      apb_write(12'h000, 32'h0000_0001);
      chk_locks("R2 bit0 sets vec lock", 2'b01);
      apb_read(12'h000, d);
      chk("R5 ctrl readback 01", d, 32'h1);
      apb_write(12'h000, 32'hFFFF_FFFC);
      chk_locks("R3 upper bits only, sticky", 2'b01);
      apb_write(12'h000, 32'h0000_0002);
      chk_locks("R2 bit1 sets attr lock", 2'b11);
      apb_write(12'h000, 32'h0);
      chk_locks("R3 zero write keeps locks", 2'b11);
      apb_read(12'h000, d);
      chk("R5 ctrl readback 11", d, 32'h3);
   endtask

   task automatic t_set_both_timing();
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h000; pwdata = 32'h3;
      @(negedge clk);
      penable = 1'b1;
      chk_locks("R2 no change before completing edge", 2'b00);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      chk_locks("R2 both set on same edge", 2'b11);
   endtask

   task automatic t_no_effect();
      // setup phase only
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h000; pwdata = 32'h3;
      @(negedge clk);
      psel = 1'b0; pwrite = 1'b0;
      @(negedge clk);
      chk_locks("R4 setup-only phase", 2'b00);
      // read with data lines set
      begin
         logic [31:0] d;
         apb_read(12'h000, d);
      end
      chk_locks("R4 read does not set", 2'b00);
      apb_write(12'h004, 32'h3);
      chk_locks("R4 reserved write", 2'b00);
      apb_write(12'hFD0, 32'h3);
      chk_locks("R4 ident write", 2'b00);
      apb_write(12'h001, 32'h3);
      chk_locks("R4 misaligned write", 2'b00);
      apb_write(12'h800, 32'h3);
      chk_locks("R4 mid-map write", 2'b00);
   endtask

   task automatic t_ident();
      logic [31:0] d;
      logic [7:0] exp [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h59, 8'hB8,
                               8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 12; i++) begin
         apb_read(12'hFD0 + 12'(i * 4), d);
         chk($sformatf("R6 R7 ident 0x%03h", 12'hFD0 + 12'(i * 4)), d, {24'd0, exp[i]});
      end
      apb_write(12'hFE0, 32'h0);
      apb_read(12'hFE0, d);
      chk("R6 ident unchanged by write", d, 32'h59);
   endtask

   task automatic t_reserved_reads();
      logic [31:0] d;
      apb_read(12'h004, d);
      chk("R7 reserved 0x004", d, 32'h0);
      apb_read(12'hFCC, d);
      chk("R7 reserved 0xFCC", d, 32'h0);
      apb_read(12'h400, d);
      chk("R7 reserved 0x400", d, 32'h0);
      apb_read(12'hFD2, d);
      chk("R7 misaligned ident", d, 32'h0);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_no_effect();
      t_ident();
      t_reserved_reads();
      t_set_each();
      do_reset();
      chk_locks("R9 locks clear after reset", 2'b00);
      t_set_both_timing();
      do_reset();
      t_reset_state();
      finished = 1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule